// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms

This block keeps wall-clock time for a chip. It takes a 32.768 kHz tick that has already been brought into the system clock domain as a single-cycle pulse. A prescaler divides that tick down to one count per second. The count drives a chain of seconds, minutes, hours and day counters. The day counter is a plain 15-bit day number, not a calendar date.

On top of the time chain sit a countdown stopwatch, an alarm on time of day only, an alarm on day number plus time of day, and four periodic tick events (second, minute, hour, day). Each event source sets a sticky status bit. Software clears a status bit by writing 1 to it. The interrupt line is the OR of the status bits that are enabled.

Software reaches everything through a simple word-wide register port. A write takes effect at the clock edge. Read data is registered and appears one cycle after the address is presented.

Top module: `rtc_core`

## Requirements
- R1: After reset the time word reads 0, the control register (address 1) reads 0, the status register (address 3) reads 0 and `irq` is low.
- R2: Counting is gated by control bit 0. While it is 0, ticks do not change the time. While it is 1, the seconds value advances by one on exactly every PRESCALE-th tick and on no other tick.
- R3: The time word (address 0) holds seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and the day number in bits 31:17. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day number.
- R4: The day number counts 0 to 32767 and wraps from 32767 to 0.
- R5: Each status bit is set by its event and stays set until it is cleared. The bits are: bit 0 on every second step, bit 1 on every minutes carry out of seconds, bit 2 on every hours carry, and bit 3 on every day carry.
- R6: Writing to address 3 clears the status bits written as 1 and leaves the bits written as 0 untouched. The interrupt enable register is at address 2. `irq` is high exactly when some status bit is set and its enable bit is also set.
- R7: The stopwatch register (address 4) is loaded by a write. While nonzero, it decrements once per second step. The step that takes it from 1 to 0 sets status bit 4, and the count then rests at 0 with no further event until a new nonzero value is written.
- R8: Alarm one (address 5, same layout as the time word, day field ignored) sets status bit 4+1=5 on any second step after which the hours, minutes and seconds equal its programmed values, on any day.
- R9: Alarm two (address 6, same layout as the time word) sets status bit 6 only on a second step after which the day number, hours, minutes and seconds all equal its programmed values.
- R10: A write to the time word loads all four counters at once and restarts the prescaler phase. The next second step then comes exactly PRESCALE ticks after the write. The write itself raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong counter state shows up in the time word by the next second step at the latest: a bad carry or wrap point shifts a field in the very read that follows. The bench reads the time, status and stopwatch after every simulated second of long sweeps across an hour boundary and across the day-number wrap. So a slip in the prescaler phase, a carry or an alarm compare is reported within one second step of where it goes wrong. A status or enable fault shows on `irq` one cycle after the edge that caused it, and the bench checks `irq` against the model after each step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int DAY_W    = 15;
  localparam int SEC_MOD  = 60;
  localparam int MIN_MOD  = 60;
  localparam int HOUR_MOD = 24;
  localparam int DAY_MOD  = 1 << DAY_W;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } rtc_time_t;

  localparam logic [ADDR_W-1:0] RA_TIME = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] RA_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] RA_SWCH = 3'd4;
  localparam logic [ADDR_W-1:0] RA_ALM1 = 3'd5;
  localparam logic [ADDR_W-1:0] RA_ALM2 = 3'd6;

  localparam int EV_SEC  = 0;
  localparam int EV_MIN  = 1;
  localparam int EV_HOUR = 2;
  localparam int EV_DAY  = 3;
  localparam int EV_SW   = 4;
  localparam int EV_AL1  = 5;
  localparam int EV_AL2  = 6;
  localparam int NUM_EV  = 7;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic restart,
  output logic sec_step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] phase_q;
  logic          at_last;

  assign at_last  = (phase_q == LAST);
  assign sec_step = run & tick & ~restart & at_last;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (run && tick) begin
      phase_q <= at_last ? '0 : phase_q + ONE;
    end
  end
endmodule

// File: rtl/rtc_mod_counter.sv
module rtc_mod_counter #(
  parameter int W   = 6,
  parameter int MOD = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] ONE  = W'(1);

  assign carry = inc & (q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (inc) begin
      q <= (q == LAST) ? '0 : q + ONE;
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now,
  output logic      ev_min,
  output logic      ev_hour,
  output logic      ev_day
);
  logic c_sec, c_min, c_hour, c_day;

  rtc_mod_counter #(.W(SEC_W), .MOD(SEC_MOD)) u_sec (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val.sec),
    .inc(step), .q(now.sec), .carry(c_sec)
  );

  rtc_mod_counter #(.W(MIN_W), .MOD(MIN_MOD)) u_min (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val.min),
    .inc(c_sec), .q(now.min), .carry(c_min)
  );

  rtc_mod_counter #(.W(HOUR_W), .MOD(HOUR_MOD)) u_hour (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val.hour),
    .inc(c_min), .q(now.hour), .carry(c_hour)
  );

  rtc_mod_counter #(.W(DAY_W), .MOD(DAY_MOD)) u_day (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val.day),
    .inc(c_hour), .q(now.day), .carry(c_day)
  );

  assign ev_min  = c_sec;
  assign ev_hour = c_min;
  assign ev_day  = c_hour;
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = step & ~load & (q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (step && (q != '0)) begin
      q <= q - ONE;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
#(
  parameter bit USE_DAY = 1'b0
) (
  input  rtc_time_t now,
  input  rtc_time_t target,
  output logic      match
);
  logic tod_eq;

  assign tod_eq = (now.hour == target.hour) &&
                  (now.min  == target.min)  &&
                  (now.sec  == target.sec);

  generate
    if (USE_DAY) begin : g_day
      assign match = tod_eq && (now.day == target.day);
    end else begin : g_tod
      assign match = tod_eq;
    end
  endgenerate
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int SW_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int NUM_ALM = 2;

  logic wr_time, wr_ctrl, wr_ien, wr_stat, wr_sw, wr_alm1, wr_alm2;

  assign wr_time = bus_wr && (bus_addr == RA_TIME);
  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
  assign wr_stat = bus_wr && (bus_addr == RA_STAT);
  assign wr_sw   = bus_wr && (bus_addr == RA_SWCH);
  assign wr_alm1 = bus_wr && (bus_addr == RA_ALM1);
  assign wr_alm2 = bus_wr && (bus_addr == RA_ALM2);

  logic              run_q;
  logic [NUM_EV-1:0] ien_q, stat_q;
  logic [NUM_EV-1:0] ien_n, stat_n, ev;
  rtc_time_t         alm_q [NUM_ALM];
  logic [NUM_ALM-1:0] alm_hit;
  logic              step_d_q;
  logic              irq_q;
  logic [DATA_W-1:0] rdata_q;

  logic       sec_step;
  rtc_time_t  now_t;
  logic       ev_min, ev_hour, ev_day;
  logic [SW_W-1:0] sw_q;
  logic       sw_expire;

  rtc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick_in),
    .restart(wr_time), .sec_step(sec_step)
  );

  rtc_timekeeper u_tk (
    .clk(clk), .rst(rst), .step(sec_step), .load(wr_time),
    .load_val(rtc_time_t'(bus_wdata)), .now(now_t),
    .ev_min(ev_min), .ev_hour(ev_hour), .ev_day(ev_day)
  );

  rtc_stopwatch #(.W(SW_W)) u_sw (
    .clk(clk), .rst(rst), .load(wr_sw), .load_val(bus_wdata[SW_W-1:0]),
    .step(sec_step), .q(sw_q), .expire(sw_expire)
  );

  generate
    for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
      logic wr_this;
      assign wr_this = (a == 0) ? wr_alm1 : wr_alm2;

      always_ff @(posedge clk) begin
        if (rst) begin
          alm_q[a] <= '0;
        end else if (wr_this) begin
          alm_q[a] <= rtc_time_t'(bus_wdata);
        end
      end

      rtc_alarm_match #(.USE_DAY(a == 1)) u_match (
        .now(now_t), .target(alm_q[a]), .match(alm_hit[a])
      );
    end
  endgenerate

  always_comb begin
    ev          = '0;
    ev[EV_SEC]  = sec_step;
    ev[EV_MIN]  = ev_min;
    ev[EV_HOUR] = ev_hour;
    ev[EV_DAY]  = ev_day;
    ev[EV_SW]   = sw_expire;
    ev[EV_AL1]  = step_d_q & alm_hit[0];
    ev[EV_AL2]  = step_d_q & alm_hit[1];
  end

  always_comb begin
    ien_n  = wr_ien ? bus_wdata[NUM_EV-1:0] : ien_q;
    stat_n = stat_q;
    if (wr_stat) begin
      stat_n = stat_n & ~bus_wdata[NUM_EV-1:0];
    end
    stat_n = stat_n | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      ien_q    <= '0;
      stat_q   <= '0;
      step_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[0];
      end
      ien_q    <= ien_n;
      stat_q   <= stat_n;
      step_d_q <= sec_step;
      irq_q    <= |(stat_n & ien_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        RA_TIME: rdata_q <= now_t;
        RA_CTRL: rdata_q <= {{(DATA_W-1){1'b0}}, run_q};
        RA_IEN:  rdata_q <= {{(DATA_W-NUM_EV){1'b0}}, ien_q};
        RA_STAT: rdata_q <= {{(DATA_W-NUM_EV){1'b0}}, stat_q};
        RA_SWCH: rdata_q <= {{(DATA_W-SW_W){1'b0}}, sw_q};
        RA_ALM1: rdata_q <= alm_q[0];
        RA_ALM2: rdata_q <= alm_q[1];
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int SW_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              wr_time,
  input logic              wr_stat,
  input logic              wr_sw,
  input rtc_time_t         now,
  input logic [NUM_EV-1:0] stat,
  input logic [NUM_EV-1:0] ien,
  input logic              irq,
  input logic [SW_W-1:0]   sw
);
  // R3
  tod_range_chk: assert property (@(posedge clk) disable iff (rst)
    (now.sec < SEC_W'(SEC_MOD)) && (now.min < MIN_W'(MIN_MOD)) &&
    (now.hour < HOUR_W'(HOUR_MOD)));

  // R2
  halt_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_time) |=> $stable(now));

  // R6
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat & ien));

  // R5
  sticky_stat_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((stat & $past(stat)) == $past(stat)));

  // R7
  sw_rest_chk: assert property (@(posedge clk) disable iff (rst)
    ((sw == '0) && !wr_sw) |=> (sw == '0));

  // R7
  sw_once_chk: assert property (@(posedge clk) disable iff (rst)
    ((sw == '0) && !wr_sw) |=> !$rose(stat[EV_SW]));
endmodule

bind rtc_core rtc_core_chk #(.SW_W(SW_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .wr_time(wr_time), .wr_stat(wr_stat),
  .wr_sw(wr_sw), .now(now_t), .stat(stat_q), .ien(ien_q), .irq(irq),
  .sw(sw_q)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int DIV  = 4;
  localparam int SW_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  int es, em, eh, ed, esw;
  int a1h, a1m, a1s, a2d, a2h, a2m, a2s;
  logic [6:0] estat;
  logic [6:0] mask;

  always #10 clk = ~clk;

  rtc_core #(.PRESCALE(DIV), .SW_W(SW_W)) u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  function automatic logic [31:0] pk(input int d, input int h, input int m, input int s);
    pk = (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic model_second();
    estat[0] = 1'b1;
    es++;
    if (es == 60) begin
      es = 0; estat[1] = 1'b1; em++;
      if (em == 60) begin
        em = 0; estat[2] = 1'b1; eh++;
        if (eh == 24) begin
          eh = 0; estat[3] = 1'b1; ed = (ed + 1) % 32768;
        end
      end
    end
    if (esw != 0) begin
      esw--;
      if (esw == 0) estat[4] = 1'b1;
    end
    if (eh == a1h && em == a1m && es == a1s) estat[5] = 1'b1;
    if (ed == a2d && eh == a2h && em == a2m && es == a2s) estat[6] = 1'b1;
  endtask

  task automatic one_second();
    logic [31:0] v;
    ticks(DIV);
    model_second();
    rd(3'd0, v);
    chk(v == pk(ed, eh, em, es), "R3 R4 time word", v, pk(ed, eh, em, es));
    rd(3'd4, v);
    chk(v == 32'(esw), "R7 stopwatch count", v, 32'(esw));
    rd(3'd3, v);
    chk(v[3:0] == estat[3:0], "R5 tick status", {28'd0, v[3:0]}, {28'd0, estat[3:0]});
    chk(v[4] == estat[4], "R7 stopwatch status", {31'd0, v[4]}, {31'd0, estat[4]});
    chk(v[5] == estat[5], "R8 alarm one status", {31'd0, v[5]}, {31'd0, estat[5]});
    chk(v[6] == estat[6], "R9 alarm two status", {31'd0, v[6]}, {31'd0, estat[6]});
    chk(irq == |(estat & mask), "R6 irq", {31'd0, irq}, {31'd0, |(estat & mask)});
    wr(3'd3, 32'h7F);
    estat = '0;
  endtask

  task automatic segment(input int d, input int h, input int m, input int s,
                         input int sw, input int secs);
    ed = d; eh = h; em = m; es = s; esw = sw;
    wr(3'd5, pk(0, a1h, a1m, a1s));
    wr(3'd6, pk(a2d, a2h, a2m, a2s));
    wr(3'd0, pk(d, h, m, s));
    wr(3'd4, 32'(sw));
    wr(3'd3, 32'h7F);
    estat = '0;
    for (int i = 0; i < secs; i++) one_second();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 time after reset", v, 0);
    rd(3'd1, v); chk(v == 0, "R1 control after reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 status after reset", v, 0);
    chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 0);

    // R2 gating and exact division
    ticks(2 * DIV);
    rd(3'd0, v); chk(v == 0, "R2 no count while disabled", v, 0);
    wr(3'd1, 32'd1);
    ticks(DIV - 1);
    rd(3'd0, v); chk(v == 0, "R2 no step before last tick", v, 0);
    ticks(1);
    rd(3'd0, v); chk(v == 1, "R2 step on last tick", v, 1);
    wr(3'd3, 32'h7F);

    // R10 load and phase restart
    ticks(2);
    wr(3'd0, pk(3, 4, 5, 6));
    rd(3'd0, v); chk(v == pk(3, 4, 5, 6), "R10 load value", v, pk(3, 4, 5, 6));
    rd(3'd3, v); chk(v == 0, "R10 load raises no event", v, 0);
    ticks(DIV - 1);
    rd(3'd0, v); chk(v == pk(3, 4, 5, 6), "R10 phase restarted", v, pk(3, 4, 5, 6));
    ticks(1);
    rd(3'd0, v); chk(v == pk(3, 4, 5, 7), "R10 step after full period", v, pk(3, 4, 5, 7));

    // R6 clear and enable behaviour
    chk(irq == 1'b0, "R6 irq masked", {31'd0, irq}, 0);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk(v == 32'h1, "R6 zero write keeps status", v, 1);
    wr(3'd2, 32'h1);
    chk(irq == 1'b1, "R6 irq when enabled", {31'd0, irq}, 1);
    wr(3'd3, 32'h1);
    rd(3'd3, v); chk(v == 0, "R6 write one clears", v, 0);
    chk(irq == 1'b0, "R6 irq after clear", {31'd0, irq}, 0);

    // Sweep across an hour boundary: alarm two misses on day
    mask = 7'h55;
    wr(3'd2, 32'(mask));
    a1h = 0; a1m = 59; a1s = 30;
    a2d = 9; a2h = 0; a2m = 59; a2s = 30;
    segment(5, 0, 59, 0, 7, 90);

    // Sweep across the day wrap: alarm one on new day, alarm two hits
    mask = 7'h2A;
    wr(3'd2, 32'(mask));
    a1h = 0; a1m = 0; a1s = 5;
    a2d = 32767; a2h = 23; a2m = 59; a2s = 20;
    segment(32767, 23, 58, 30, 100, 120);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule